// File: doc/BRIEF.md
# Width-Selectable Synchronous FIFO with Level Comparators

This block is a synchronous first-in first-out buffer for either direction of a serial port. A fixed byte store is seen as byte, halfword or word entries, depending on a width code in the control word. The capacity in entries therefore follows the width. An operation strobe clears the buffer, starts it or stops it. While the buffer is stopped, push and pop requests are ignored.

A status word gives the level in entries and the full and empty flags. A programmable threshold drives a threshold-reached flag, and its sense is fixed by a parameter for the receive or transmit variant. The same parameter picks the side flag: full on the receive side, empty on the transmit side. Three 6-bit check levels (stop, low, high) are packed into one check word, and each one drives its own compare output. A push that meets a full buffer and a pop that meets an empty buffer each give a one-cycle error pulse.

Top module: `tri_level_fifo`

## Requirements
- R1: `ctrl_word[1:0]` selects the entry size: 0 gives bytes (256 entries), 1 gives halfwords (128 entries), 2 or 3 gives 32-bit words (64 entries). Only the low bits of `push_data` that fit the entry are stored, and `pop_data` is zero-extended.
- R2: Entries leave in the order they were pushed. `pop_data` takes the popped entry at the clock edge that accepts the pop, and holds its value when no pop is accepted.
- R3: `status_word[7:0]` is the level in entries modulo 256, `status_word[8]` is full and `status_word[9]` is empty. All three follow the clock edge that changes the contents.
- R4: When `op_wr` is high, `op_word[0]` empties the buffer and leaves it stopped, even if `op_word[1]` is also set. Otherwise `op_word[1]=1` starts the buffer and `op_word=0` stops it with its contents kept. Push and pop are ignored in a cycle with `op_wr` high.
- R5: While the buffer is stopped, push and pop change neither the contents nor `pop_data`.
- R6: A push to a full, started buffer is dropped, and `ovf_pulse` is high for the one cycle after it.
- R7: A pop from an empty, started buffer leaves `pop_data` at its last value, and `udf_pulse` is high for the one cycle after it.
- R8: The threshold is `ctrl_word[9:2]`, counted in entries. `thr_hit` means level >= threshold in the receive variant (`IS_RX=1`) and level <= threshold in the transmit variant.
- R9: `side_flag` equals full in the receive variant and empty in the transmit variant.
- R10: The check word holds stop in bits 5:0, low in bits 15:10 and high in bits 25:20. `at_stop`, `at_low` and `at_high` are each high while the level in entries is >= the matching count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 10 | Width code [1:0], threshold [9:2] |
| chk_word | input | 26 | Stop [5:0], low [15:10], high [25:20] |
| op_wr | input | 1 | Strobe for the operation bits |
| op_word | input | 2 | Bit 0 clears, bit 1 starts |
| push | input | 1 | Push request |
| push_data | input | DATA_W | Entry to push |
| pop | input | 1 | Pop request |
| pop_data | output | DATA_W | Last popped entry |
| status_word | output | 10 | Level, full, empty |
| thr_hit | output | 1 | Threshold reached |
| side_flag | output | 1 | Full (receive) or empty (transmit) |
| at_stop | output | 1 | Level >= stop count |
| at_low | output | 1 | Level >= low count |
| at_high | output | 1 | Level >= high count |
| ovf_pulse | output | 1 | Dropped push |
| udf_pulse | output | 1 | Pop from empty |

## Verification
The assertions check, on every cycle, that the byte count never exceeds the store and that full and empty are never set together. They also check that a stopped buffer and a dropped push leave the count unchanged, that a clear leaves the buffer empty and stopped, and that `pop_data` holds when no pop is accepted. Only the bench scenarios can show the data order and truncation in each width mode, the level field wrapping to zero when byte mode is full, and the threshold sense of both variants. They also show the three check compares and that contents survive a stop and a later start.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
   localparam int THR_LSB   = 2;
   localparam int THR_W     = 8;
   localparam int CHK_W     = 6;
   localparam int STOP_LSB  = 0;
   localparam int LOW_LSB   = 10;
   localparam int HIGH_LSB  = 20;
   localparam int STAT_LVL_W = 8;

   typedef enum logic [1:0] {
      WM_BYTE = 2'd0,
      WM_HALF = 2'd1,
      WM_WORD = 2'd2,
      WM_WIDE = 2'd3
   } width_mode_e;

   // log2 of the bytes per entry for a width code
   function automatic logic [1:0] entry_shift(input logic [1:0] code);
      case (width_mode_e'(code))
         WM_BYTE: entry_shift = 2'd0;
         WM_HALF: entry_shift = 2'd1;
         default: entry_shift = 2'd2;
      endcase
   endfunction
endpackage

// File: rtl/tlf_store.sv
module tlf_store #(
   parameter int STORE_BYTES = 256,
   parameter int DATA_W      = 32,
   localparam int PTR_W      = $clog2(STORE_BYTES),
   localparam int LANES      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic [1:0]        shift,
   output logic [DATA_W-1:0] rd_data
);
   logic [7:0] mem [STORE_BYTES];

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (wr_en && ((k >> shift) == 0))
            mem[wr_ptr + PTR_W'(k)] <= wr_data[8*k +: 8];
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < LANES; k++) begin
         if ((k >> shift) == 0)
            rd_data[8*k +: 8] = mem[rd_ptr + PTR_W'(k)];
      end
   end
endmodule

// File: rtl/tlf_ctrl.sv
module tlf_ctrl #(
   parameter int STORE_BYTES = 256,
   localparam int PTR_W      = $clog2(STORE_BYTES),
   localparam int CNT_W      = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_wr,
   input  logic [1:0]       op_word,
   input  logic             push,
   input  logic             pop,
   input  logic [1:0]       shift,
   output logic             wr_en,
   output logic             rd_en,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] byte_cnt,
   output logic             full,
   output logic             empty,
   output logic             running,
   output logic             ovf_pulse,
   output logic             udf_pulse
);
   localparam logic [CNT_W-1:0] STORE_C = CNT_W'(STORE_BYTES);

   logic [CNT_W-1:0] nb;
   logic [CNT_W-1:0] add_b, sub_b;

   assign nb    = CNT_W'(1) << shift;
   assign full  = (STORE_C - byte_cnt) < nb;
   assign empty = byte_cnt < nb;
   assign wr_en = running && !op_wr && push && !full;
   assign rd_en = running && !op_wr && pop && !empty;
   assign add_b = wr_en ? nb : '0;
   assign sub_b = rd_en ? nb : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         byte_cnt  <= '0;
         running   <= 1'b0;
         ovf_pulse <= 1'b0;
         udf_pulse <= 1'b0;
      end else if (op_wr) begin
         ovf_pulse <= 1'b0;
         udf_pulse <= 1'b0;
         if (op_word[0]) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            byte_cnt <= '0;
            running  <= 1'b0;
         end else begin
            running  <= op_word[1];
         end
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + PTR_W'(nb);
         if (rd_en) rd_ptr <= rd_ptr + PTR_W'(nb);
         byte_cnt  <= byte_cnt + add_b - sub_b;
         ovf_pulse <= running && push && full;
         udf_pulse <= running && pop && empty;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      byte_cnt <= STORE_C); // R6
   AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R3
   AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (running && push && full && !pop && !op_wr) |=> (byte_cnt == $past(byte_cnt))); // R6
   AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !op_wr) |=> ($stable(byte_cnt) && $stable(rd_ptr))); // R5
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && op_word[0]) |=> (byte_cnt == '0 && !running)); // R4
   AST_UDF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      udf_pulse |-> $past(running && pop && empty && !op_wr)); // R7
endmodule

// File: rtl/tlf_cmp.sv
module tlf_cmp #(
   parameter bit IS_RX = 1'b1,
   parameter int CNT_W = 9
) (
   input  logic [CNT_W-1:0]        level,
   input  logic [tlf_pkg::THR_W-1:0] thresh,
   input  logic [tlf_pkg::CHK_W-1:0] stop_lvl,
   input  logic [tlf_pkg::CHK_W-1:0] low_lvl,
   input  logic [tlf_pkg::CHK_W-1:0] high_lvl,
   input  logic                    full,
   input  logic                    empty,
   output logic                    thr_hit,
   output logic                    side_flag,
   output logic                    at_stop,
   output logic                    at_low,
   output logic                    at_high
);
   localparam int CW = (CNT_W > tlf_pkg::THR_W) ? CNT_W : tlf_pkg::THR_W;

   logic [CW-1:0] lvl_x, thr_x;
   assign lvl_x = CW'(level);
   assign thr_x = CW'(thresh);

   generate
      if (IS_RX) begin : g_rx
         assign thr_hit   = lvl_x >= thr_x;
         assign side_flag = full;
         logic unused_rx;
         assign unused_rx = empty;
      end else begin : g_tx
         assign thr_hit   = lvl_x <= thr_x;
         assign side_flag = empty;
         logic unused_tx;
         assign unused_tx = full;
      end
   endgenerate

   assign at_stop = lvl_x >= CW'(stop_lvl);
   assign at_low  = lvl_x >= CW'(low_lvl);
   assign at_high = lvl_x >= CW'(high_lvl);
endmodule

// File: rtl/tri_level_fifo.sv
module tri_level_fifo #(
   parameter int STORE_BYTES = 256,
   parameter int DATA_W      = 32,
   parameter bit IS_RX       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [9:0]        ctrl_word,
   input  logic [25:0]       chk_word,
   input  logic              op_wr,
   input  logic [1:0]        op_word,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [9:0]        status_word,
   output logic              thr_hit,
   output logic              side_flag,
   output logic              at_stop,
   output logic              at_low,
   output logic              at_high,
   output logic              ovf_pulse,
   output logic              udf_pulse
);
   import tlf_pkg::*;

   localparam int PTR_W = $clog2(STORE_BYTES);
   localparam int CNT_W = PTR_W + 1;

   initial begin
      assert ((STORE_BYTES & (STORE_BYTES - 1)) == 0 && STORE_BYTES >= 4)
         else $error("STORE_BYTES must be a power of two of at least 4");
      assert (DATA_W >= 32 && DATA_W % 8 == 0)
         else $error("DATA_W must hold a word entry");
   end

   logic [1:0]        shift;
   logic              wr_en, rd_en, full, empty, running;
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  byte_cnt, level;
   logic [DATA_W-1:0] rd_data, push_masked;

   assign shift = entry_shift(ctrl_word[1:0]);
   assign level = byte_cnt >> shift;

   always_comb begin
      push_masked = '0;
      case (shift)
         2'd0:    push_masked[7:0]  = push_data[7:0];
         2'd1:    push_masked[15:0] = push_data[15:0];
         default: push_masked[31:0] = push_data[31:0];
      endcase
   end

   tlf_ctrl #(.STORE_BYTES(STORE_BYTES)) i_ctrl (
      .clk, .rst_n, .op_wr, .op_word, .push, .pop, .shift,
      .wr_en, .rd_en, .wr_ptr, .rd_ptr, .byte_cnt, .full, .empty,
      .running, .ovf_pulse, .udf_pulse
   );

   tlf_store #(.STORE_BYTES(STORE_BYTES), .DATA_W(DATA_W)) i_store (
      .clk, .wr_en, .wr_ptr, .wr_data(push_masked), .rd_ptr, .shift, .rd_data
   );

   tlf_cmp #(.IS_RX(IS_RX), .CNT_W(CNT_W)) i_cmp (
      .level,
      .thresh  (ctrl_word[THR_LSB +: THR_W]),
      .stop_lvl(chk_word[STOP_LSB +: CHK_W]),
      .low_lvl (chk_word[LOW_LSB +: CHK_W]),
      .high_lvl(chk_word[HIGH_LSB +: CHK_W]),
      .full, .empty, .thr_hit, .side_flag, .at_stop, .at_low, .at_high
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pop_data <= '0;
      else if (rd_en) pop_data <= rd_data;
   end

   assign status_word = {empty, full, level[STAT_LVL_W-1:0]};

   logic unused_bits;
   assign unused_bits = ^{chk_word[9:6], chk_word[19:16], running, level};

   AST_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(pop_data)); // R2
endmodule

// File: tb/test_tri_level_fifo.sv
`timescale 1ns/1ps
module test_tri_level_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  ctrl_word = '0;
   logic [25:0] chk_word = '0;
   logic        op_wr = 1'b0;
   logic [1:0]  op_word = '0;
   logic        push = 1'b0, pop = 1'b0;
   logic [31:0] push_data = '0;
   logic [31:0] pop_data, pop_data_tx;
   logic [9:0]  status_word, status_tx;
   logic        thr_hit, side_flag, at_stop, at_low, at_high, ovf_pulse, udf_pulse;
   logic        thr_tx, side_tx, st_tx, lo_tx, hi_tx, ovf_tx, udf_tx;

   always #4 clk = ~clk;

   tri_level_fifo #(.IS_RX(1'b1)) i_tri_level_fifo (
      .clk, .rst_n, .ctrl_word, .chk_word, .op_wr, .op_word, .push, .push_data,
      .pop, .pop_data, .status_word, .thr_hit, .side_flag, .at_stop, .at_low,
      .at_high, .ovf_pulse, .udf_pulse);

   tri_level_fifo #(.IS_RX(1'b0)) i_tri_level_fifo_tx (
      .clk, .rst_n, .ctrl_word, .chk_word, .op_wr, .op_word, .push, .push_data,
      .pop, .pop_data(pop_data_tx), .status_word(status_tx), .thr_hit(thr_tx),
      .side_flag(side_tx), .at_stop(st_tx), .at_low(lo_tx), .at_high(hi_tx),
      .ovf_pulse(ovf_tx), .udf_pulse(udf_tx));

   int nchk = 0, nerr = 0;
   logic [31:0] q[$];
   bit          started = 0;
   int          cap = 256;
   logic [31:0] mask = 32'hFF;
   logic [31:0] last = '0;

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic set_mode(input logic [1:0] w, input logic [7:0] thr);
      @(negedge clk);
      ctrl_word = {thr, w};
      cap  = (w == 2'd0) ? 256 : (w == 2'd1) ? 128 : 64;
      mask = (w == 2'd0) ? 32'hFF : (w == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endtask

   task automatic do_op(input logic [1:0] v);
      @(negedge clk); op_wr = 1'b1; op_word = v;
      @(negedge clk); op_wr = 1'b0; op_word = '0;
      if (v[0]) begin q.delete(); started = 0; end
      else started = v[1];
   endtask

   // driver: pushes into the scoreboard queue what the design should keep
   task automatic do_push(input logic [31:0] d, output bit dropped);
      @(negedge clk); push = 1'b1; push_data = d;
      dropped = started && (q.size() == cap);
      if (started && q.size() < cap) q.push_back(d & mask);
      @(negedge clk); push = 1'b0;
   endtask

   // monitor: compares the design's popped entry against the queue head
   task automatic do_pop(input string r, output bit under);
      logic [31:0] exp;
      @(negedge clk); pop = 1'b1;
      under = started && (q.size() == 0);
      if (started && q.size() > 0) begin exp = q.pop_front(); last = exp; end
      else exp = last;
      @(negedge clk); pop = 1'b0;
      check(r, pop_data, exp);
   endtask

   task automatic check_status(input string r);
      logic [8:0] n;
      n = 9'(q.size());
      check({r, " status"}, 32'(status_word),
            32'({q.size() == 0, q.size() == cap, n[7:0]}));
      check({r, " status tx"}, 32'(status_tx), 32'(status_word));
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      bit fl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R3)
      check("R3 reset", 32'(status_word), 32'h200);
      check("R6 reset ovf", 32'(ovf_pulse), 0);
      // stopped buffer ignores push (R5)
      do_push(32'h55, fl);
      check_status("R5 push while stopped");

      // byte mode, threshold 4 (R1, R8, R10)
      set_mode(2'd0, 8'd4);
      chk_word = {6'd6, 4'd0, 6'd5, 4'd0, 6'd2};
      do_op(2'b10);
      for (int i = 0; i < 5; i++) do_push(32'h1A0 + 32'(i), fl);
      check_status("R3 five bytes");
      check("R8 rx thr", 32'(thr_hit), 1);
      check("R8 tx thr", 32'(thr_tx), 0);
      check("R10 stop", 32'(at_stop), 1);
      check("R10 low", 32'(at_low), 1);
      check("R10 high", 32'(at_high), 0);
      for (int i = 0; i < 5; i++) do_pop("R1 R2 byte order", fl);
      check("R8 tx thr empty", 32'(thr_tx), 1);
      check("R9 tx side empty", 32'(side_tx), 1);
      // underflow (R7)
      @(negedge clk); pop = 1'b1;
      @(negedge clk); pop = 1'b0;
      check("R7 udf pulse", 32'(udf_pulse), 1);
      check("R7 data held", pop_data, last);
      @(negedge clk);
      check("R7 pulse ends", 32'(udf_pulse), 0);

      // word mode fill and overflow (R1, R3, R6, R9)
      set_mode(2'd2, 8'd60);
      for (int i = 0; i < 64; i++) do_push(32'hC0DE_0000 + 32'(i * 7), fl);
      check_status("R3 word full");
      check("R9 rx side full", 32'(side_flag), 1);
      check("R8 rx thr at 64", 32'(thr_hit), 1);
      do_push(32'hDEAD_BEEF, fl);
      check("R6 ovf pulse", 32'(ovf_pulse), 1);
      check("R6 drop model", 32'(fl), 1);
      check_status("R6 level kept");
      for (int i = 0; i < 64; i++) do_pop("R2 word order", fl);
      check_status("R3 word drained");

      // halfword truncation and capacity (R1)
      set_mode(2'd1, 8'd0);
      do_push(32'h0001_2345, fl);
      do_pop("R1 half truncation", fl);
      for (int i = 0; i < 128; i++) do_push(32'(i * 3 + 1), fl);
      check_status("R1 half capacity");
      for (int i = 0; i < 128; i++) do_pop("R2 half order", fl);

      // byte mode full wraps level field (R3)
      set_mode(2'd0, 8'd200);
      for (int i = 0; i < 256; i++) do_push(32'(i ^ 8'h5A), fl);
      check_status("R3 byte full wrap");
      check("R9 tx side full", 32'(side_tx), 0);
      for (int i = 0; i < 253; i++) do_pop("R2 byte drain", fl);

      // stop keeps contents, pops ignored (R4, R5)
      do_op(2'b00);
      do_pop("R5 pop while stopped", fl);
      check_status("R5 stopped level");
      do_op(2'b10);
      do_pop("R4 contents kept", fl);

      // clear has priority over start (R4)
      do_op(2'b11);
      check_status("R4 cleared");
      do_push(32'h77, fl);
      check_status("R4 stays stopped");
      finish_run();
   end
endmodule